// File: doc/BRIEF.md
# Timer Interrupt Status and Test Register

This block is an 8-bit control and status register that sits next to a group of up to three timer channels. Each channel's terminal-count output is brought into the clock domain through a synchronizer. A rising edge on that output sets a sticky status bit. Software clears a status bit by writing 1 to it.

The register drives an interrupt request line. The line is gated by a global enable and by a mask input for each channel.

Four read/write control bits support debug work:
- A forced-interrupt bit raises the interrupt request directly.
- A timer test mode bit turns off the timer output drivers and ignores the external gate inputs.
- Two test-gate bits replace the external gate inputs of the first two channels whenever the forced-interrupt bit is set.

Reads are combinational from the register state. Writes take effect at the next clock edge. Reset is synchronous and active high.

Top module: `tmr_irq_stat_reg`

## Requirements
- R1: After synchronous reset the register reads 0x00. The interrupt line is low, all output enables are 1, and each gate output follows its external input.
- R2: Bits 7..4 are read/write. A write loads `wr_data[7:4]`, and the value reads back on the next cycle. Bit 7 is forced-interrupt, bit 6 is timer test mode, bit 5 is test-gate for channel index 1, and bit 4 is test-gate for channel index 0.
- R3: Bit 3 reads 0 whatever value is written to it.
- R4: Status bit n (bit position n, n = 0..2) sets on a 0-to-1 change of `tmr_out[n]`. It shows in `rd_data` after the third rising clock edge following the change, and not after the second. A level that stays high does not set the bit again once it has been cleared.
- R5: Writing 1 to a status bit clears it on the next edge. Writing 0 to a status bit leaves it unchanged. Only the bits written as 1 are affected.
- R6: If a rising edge is detected in the same cycle that a clearing write hits the same bit, the bit ends up set.
- R7: When bit 6 is 1, all `tmr_oe` bits are 0. Otherwise all `tmr_oe` bits are 1.
- R8: For each gate g (0 or 1), `gate_mux[g]` depends on the control bits as follows:
  - If bit 7 is 1, `gate_mux[g]` equals register bit 4+g.
  - Else if bit 6 is 1, `gate_mux[g]` is 0.
  - Otherwise `gate_mux[g]` equals `gate_ext[g]`.
- R9: `irq` equals `irq_en` AND (any status bit whose `ch_mask` bit is 1, OR bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| irq_en | input | 1 | Global interrupt enable |
| ch_mask | input | NUM_CH | Per-channel interrupt mask, 1 = enabled |
| tmr_out | input | NUM_CH | Timer terminal-count outputs |
| tmr_oe | output | NUM_CH | Timer output drive enables |
| gate_ext | input | NUM_GATE | External timer gate inputs |
| gate_mux | output | NUM_GATE | Gate inputs delivered to the timers |
| irq | output | 1 | Interrupt request |

## Verification
The control field is swept through all 256 write values, which separates the stored bits from the reserved bit and from the status bits. All 16 control combinations are crossed with all four external gate patterns. This tells apart a forced gate source, a blocked external input and a pass-through input. The interrupt output is checked for every pairing of status pattern, mask, enable and forced-interrupt bit, so a wrong mask polarity, a missed OR term or a missed enable gate each show up. Single-channel edge sequences check the three-edge latency, re-arming on a held level, selective clearing and the case where a set and a clear land on the same edge.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int REG_W    = 8;
   localparam int STAT_MAX = 3;
   localparam int GATE_MAX = 2;
   localparam int CTRL_LSB = 4;

   // control field, maps directly onto register bits 7..4
   typedef struct packed {
      logic       itest;   // bit 7
      logic       tmode;   // bit 6
      logic [1:0] tin;     // bits 5..4
   } ctrl_t;
endpackage

// File: rtl/tmr_edge_sticky.sv
module tmr_edge_sticky #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tmr_level,
   input  logic clr_req,
   output logic sticky
);
   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sticky_q;
   logic                   rise;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[TOP-1:0], tmr_level};
         prev_q <= sync_q[TOP];
      end
   end

   assign rise = sync_q[TOP] & ~prev_q;

   always_ff @(posedge clk) begin
      if (rst)
         sticky_q <= 1'b0;
      else
         sticky_q <= rise | (sticky_q & ~clr_req);
   end

   assign sticky = sticky_q;

   // R4
   rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> sticky_q);
   // R5
   clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_req && !rise) |=> !sticky_q);
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_req && !rise) |=> $stable(sticky_q));
   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_req && rise) |=> sticky_q);
endmodule

// File: rtl/tmr_test_route.sv
module tmr_test_route
   import tmr_irq_pkg::*;
#(
   parameter int NUM_CH   = 3,
   parameter int NUM_GATE = 2
) (
   input  ctrl_t               ctrl,
   input  logic [NUM_GATE-1:0] gate_ext,
   output logic [NUM_GATE-1:0] gate_mux,
   output logic [NUM_CH-1:0]   tmr_oe
);
   generate
      if (NUM_GATE < 1 || NUM_GATE > GATE_MAX) begin : g_bad_gate
         $error("NUM_GATE out of range");
      end
      for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate
         always_comb begin
            if (ctrl.itest)      gate_mux[g] = ctrl.tin[g];
            else if (ctrl.tmode) gate_mux[g] = 1'b0;
            else                 gate_mux[g] = gate_ext[g];
         end
      end
   endgenerate

   assign tmr_oe = {NUM_CH{~ctrl.tmode}};
endmodule

// File: rtl/tmr_irq_stat_reg.sv
module tmr_irq_stat_reg
   import tmr_irq_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int NUM_GATE    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   input  logic                irq_en,
   input  logic [NUM_CH-1:0]   ch_mask,
   input  logic [NUM_CH-1:0]   tmr_out,
   output logic [NUM_CH-1:0]   tmr_oe,
   input  logic [NUM_GATE-1:0] gate_ext,
   output logic [NUM_GATE-1:0] gate_mux,
   output logic                irq
);
   localparam int PAD = STAT_MAX - NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > STAT_MAX) begin : g_bad_ch
         $error("NUM_CH out of range");
      end
      if (NUM_GATE > NUM_CH) begin : g_bad_mix
         $error("NUM_GATE exceeds NUM_CH");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [NUM_CH-1:0] status;

   always_ff @(posedge clk) begin
      if (rst)        ctrl_q <= '0;
      else if (wr_en) ctrl_q <= ctrl_t'(wr_data[REG_W-1:CTRL_LSB]);
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tmr_edge_sticky #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk       (clk),
            .rst       (rst),
            .tmr_level (tmr_out[c]),
            .clr_req   (wr_en & wr_data[c]),
            .sticky    (status[c])
         );
      end
      if (PAD > 0) begin : g_pad
         assign rd_data = {ctrl_q, 1'b0, {PAD{1'b0}}, status};
      end else begin : g_nopad
         assign rd_data = {ctrl_q, 1'b0, status};
      end
   endgenerate

   tmr_test_route #(.NUM_CH(NUM_CH), .NUM_GATE(NUM_GATE)) u_route (
      .ctrl     (ctrl_q),
      .gate_ext (gate_ext),
      .gate_mux (gate_mux),
      .tmr_oe   (tmr_oe)
   );

   assign irq = irq_en & ((|(status & ch_mask)) | ctrl_q.itest);

   // R2
   ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> rd_data[7:4] == $past(wr_data[7:4]));
   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[3] == 1'b0);
   // R7
   oe_off_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[6] |-> tmr_oe == '0);
   // R8
   gate_test_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[7] |-> gate_mux == rd_data[4 +: NUM_GATE]);
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_en |-> !irq);
   // R9
   irq_status_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_en && (|(status & ch_mask))) |-> irq);
endmodule

// File: tb/sim_tmr_irq_stat_reg.sv
module sim_tmr_irq_stat_reg;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq_en = 1'b0;
   logic [2:0] ch_mask = '0;
   logic [2:0] tmr_out = '0;
   logic [2:0] tmr_oe;
   logic [1:0] gate_ext = 2'b10;
   logic [1:0] gate_mux;
   logic       irq;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   tmr_irq_stat_reg u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .irq_en(irq_en), .ch_mask(ch_mask), .tmr_out(tmr_out), .tmr_oe(tmr_oe),
      .gate_ext(gate_ext), .gate_mux(gate_mux), .irq(irq)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1;
      wr_data = v;
      tick();
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic raise(input logic [2:0] p);
      tmr_out = p;
      repeat (3) tick();
      tmr_out = '0;
      repeat (3) tick();
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      // R1 reset state
      chk("R1 rd", rd_data, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 oe", tmr_oe, 3'b111);
      chk("R1 gate", gate_mux, 2'b10);

      // R2 R3 sweep all write values; status stays 0
      for (int v = 0; v < 256; v++) begin
         wr(v[7:0]);
         chk("R2 ctrl", rd_data[7:4], v[7:4]);
         chk("R3 rsvd", rd_data[3:0], 4'h0);
      end
      wr(8'h00);

      // R7 R8 control x external gate sweep
      for (int c = 0; c < 16; c++) begin
         wr({c[3:0], 4'h0});
         for (int e = 0; e < 4; e++) begin
            logic [1:0] eg;
            gate_ext = e[1:0];
            #1;
            eg = c[3] ? c[1:0] : (c[2] ? 2'b00 : e[1:0]);
            chk("R8 gate", gate_mux, eg);
            chk("R7 oe", tmr_oe, c[2] ? 3'b000 : 3'b111);
         end
      end
      wr(8'h00);

      // R4 latency on channel 1
      tmr_out = 3'b010;
      tick(); tick();
      chk("R4 not yet", rd_data[2:0], 3'b000);
      tick();
      chk("R4 set", rd_data[2:0], 3'b010);
      // R5 write 0 keeps
      wr(8'h00);
      chk("R5 zero keeps", rd_data[2:0], 3'b010);
      // R5 clear while held high, R4 no re-set
      wr(8'h02);
      chk("R5 clear", rd_data[2:0], 3'b000);
      repeat (5) tick();
      chk("R4 held no reset", rd_data[2:0], 3'b000);
      tmr_out = '0;
      repeat (3) tick();

      // R5 selective clear
      raise(3'b111);
      chk("R4 all set", rd_data[2:0], 3'b111);
      wr(8'h02);
      chk("R5 selective", rd_data[2:0], 3'b101);
      wr(8'h07);
      chk("R5 clear all", rd_data[2:0], 3'b000);

      // R6 set wins over same-edge clear on channel 2
      tmr_out = 3'b100;
      tick(); tick();
      wr(8'h04);
      chk("R6 set wins", rd_data[2:0], 3'b100);
      tmr_out = '0;
      repeat (3) tick();
      wr(8'h07);

      // R9 full sweep
      for (int s = 0; s < 8; s++) begin
         wr(8'h07);
         raise(s[2:0]);
         chk("R4 pattern", rd_data[2:0], s[2:0]);
         for (int it = 0; it < 2; it++) begin
            wr({it[0], 7'h00});
            for (int m = 0; m < 8; m++) begin
               for (int en = 0; en < 2; en++) begin
                  logic ei;
                  ch_mask = m[2:0];
                  irq_en = en[0];
                  #1;
                  ei = en[0] & (((s[2:0] & m[2:0]) != 3'b000) | it[0]);
                  chk("R9 irq", irq, ei);
               end
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule